// File: doc/BRIEF.md
# Four-line LRU instruction line cache

This block sits between a processor core's 16-bit program counter and a slow, time-sliced shared main memory. The program counter addresses 32-bit words. The cache keeps four lines of eight words each. A fetch that finds its line returns the instruction word in the same cycle. A fetch that misses holds the pipeline with `stall` while the line is fetched word by word from shared memory. The line that was read least recently is overwritten, whichever task issued the fetch. Instruction lines are private to this block and are never shared with any data-read cache.

Two build-time options change the organisation. `DIRECT_MAP` replaces the four-way tag search with a single candidate line chosen by PC bits 4:3. The same index decides both hit and replacement. `PREFETCH_EN` lets the block fetch the next sequential line while the core runs from the current one. This helps most when a single task executes from shared memory. A `flush` input empties the cache in one cycle.

The fetch side is a valid/ready pair. `fetch_req` is valid, `stall` is the inverted ready, and `fetch_word` is taken when `fetch_req` is high and `stall` is low. While `stall` is high the core must keep `fetch_req` and `fetch_pc` steady for any number of cycles. The refill side applies back-pressure only from memory: `mem_req` and `mem_addr` stay steady until the cache has taken eight words, one word in each cycle that `mem_gnt` is high. Gaps of any length between grants are allowed.

Top module: `icache_lru4`

## Requirements
- R1: After reset no line is valid. `stall` and `mem_req` are low while no fetch is presented, and the first fetch of any address misses.
- R2: A fetch whose line is valid returns the word selected by PC bits 2:0 of that line in the same cycle, with `stall` low.
- R3: On a miss, `stall` goes high in the same cycle. From the next cycle `mem_req` is high with `mem_addr` equal to the PC with bits 2:0 cleared (tag = PC bits 15:3). `mem_addr` stays stable while `mem_req` is high.
- R4: Refill takes the k-th granted word (k = 0..7) as word k of the line, with any gap between grants. The line becomes valid after the eighth word, `mem_req` drops the next cycle, and the stalled fetch completes one cycle after the last word. With a grant in every cycle, that is nine cycles after the miss cycle.
- R5: In associative mode the refill target is an invalid line (lowest index first) or else the line whose last read or fill is oldest. The two-bit ages of the lines always form a permutation of 0..3.
- R6: In associative mode, any four distinct line addresses can be resident together, and no two valid lines hold the same tag.
- R7: With `DIRECT_MAP`=1, line PC[4:3] is the only place an address may live. Two addresses with equal PC[4:3] and different tags evict each other.
- R8: With `PREFETCH_EN`=1, a hit on line T while no refill is running, with line T+1 absent, starts a refill of T+1 (`mem_addr` = (T+1)<<3) on the next cycle. That refill never evicts line T, and a later fetch of T+1 then hits.
- R9: A demand miss to a different line during a prefetch abandons it and leaves that line invalid. The demand refill starts one cycle later. A demand fetch to the line being prefetched stalls until that refill completes.
- R10: `flush` invalidates every line at the next clock edge. A refill in progress is abandoned, `mem_req` is low the next cycle, and the partly filled line stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines, abandon any refill |
| fetch_req | input | 1 | Fetch address valid |
| fetch_pc | input | 16 | Word address of the instruction |
| stall | output | 1 | Fetch not ready; hold the pipeline |
| fetch_word | output | 32 | Instruction word, valid when fetch_req and not stall |
| mem_req | output | 1 | Refill request to shared memory |
| mem_addr | output | 16 | Base word address of the line being refilled |
| mem_gnt | input | 1 | One refill word is present on mem_data |
| mem_data | input | 32 | Refill word |

## Verification
A corrupted tag or valid bit shows as a wrong `fetch_word` or as a hit where a miss belongs, on the very fetch that touches the line. A wrong age order shows a few fetches later, when a line that should have survived comes back as a miss and raises `mem_req` with its own address. A word counter that skips or repeats corrupts the word at one offset of a line, and it also moves the stall length away from nine cycles. A prefetch that was not properly dropped shows as a hit on a line that should still be invalid, or as a demand stall that ends two cycles early or late.

// File: rtl/icache_pkg.sv
package icache_pkg;
  parameter int unsigned LINES  = 4;
  parameter int unsigned WORDS  = 8;
  parameter int unsigned PC_W   = 16;
  parameter int unsigned WORD_W = 32;

  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned OFS_W = $clog2(WORDS);
  localparam int unsigned TAG_W = PC_W - OFS_W;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef idx_t [LINES-1:0]  age_vec_t;

  // Mark line l as just used: every line younger than it ages by one.
  function automatic age_vec_t age_touch(age_vec_t a, idx_t l);
    age_vec_t r;
    r = a;
    for (int i = 0; i < LINES; i++) begin
      if (a[i] < a[l]) r[i] = a[i] + 1'b1;
    end
    r[l] = '0;
    return r;
  endfunction

  // Replacement choice: first invalid line, else the oldest valid line.
  // One line may be excluded from the choice.
  function automatic idx_t pick_victim(logic [LINES-1:0] vld, age_vec_t a,
                                       logic excl, idx_t ex);
    idx_t best;
    idx_t best_age;
    logic got_inv;
    logic got_any;
    best     = '0;
    best_age = '0;
    got_inv  = 1'b0;
    got_any  = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!(excl && (idx_t'(i) == ex))) begin
        if (!vld[i]) begin
          if (!got_inv) begin
            best    = idx_t'(i);
            got_inv = 1'b1;
          end
        end else if (!got_inv && (!got_any || a[i] > best_age)) begin
          best     = idx_t'(i);
          best_age = a[i];
          got_any  = 1'b1;
        end
      end
    end
    return best;
  endfunction
endpackage

// File: rtl/icache_lookup.sv
module icache_lookup
  import icache_pkg::*;
#(
  parameter bit DIRECT = 1'b0
) (
  input  logic [LINES-1:0] valid,
  input  tag_t [LINES-1:0] tags,
  input  tag_t             probe,
  output logic             hit,
  output idx_t             idx
);
  generate
    if (DIRECT) begin : g_direct
      always_comb begin
        idx = probe[IDX_W-1:0];
        hit = valid[idx] && (tags[idx] == probe);
      end
    end else begin : g_assoc
      logic [LINES-1:0] match;
      for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign match[i] = valid[i] && (tags[i] == probe);
      end
      always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < LINES; i++) begin
          if (match[i]) idx = idx_t'(i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/icache_lru.sv
module icache_lru
  import icache_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     touch_a,
  input  idx_t     line_a,
  input  logic     touch_b,
  input  idx_t     line_b,
  output age_vec_t ages
);
  age_vec_t ages_q;
  age_vec_t step_a;
  age_vec_t step_b;

  always_comb begin
    step_a = touch_a ? age_touch(ages_q, line_a) : ages_q;
    step_b = touch_b ? age_touch(step_a, line_b) : step_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) ages_q[i] <= idx_t'(i);
    end else begin
      ages_q <= step_b;
    end
  end

  assign ages = ages_q;

  logic [LINES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < LINES; i++) seen[ages_q[i]] = 1'b1;
  end

  // R5: ages stay a permutation, so exactly one line is the oldest
  assert_age_permutation_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == LINES);
endmodule

// File: rtl/icache_fill.sv
module icache_fill
  import icache_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            abort,
  input  logic            start,
  input  tag_t            start_tag,
  input  idx_t            start_line,
  input  logic            mem_gnt,
  output logic            mem_req,
  output logic [PC_W-1:0] mem_addr,
  output logic            busy,
  output tag_t            fill_tag,
  output idx_t            fill_line,
  output logic            wr_en,
  output ofs_t            wr_ofs,
  output logic            done
);
  localparam ofs_t LAST = ofs_t'(WORDS - 1);

  logic busy_q;
  ofs_t cnt_q;
  tag_t tag_q;
  idx_t line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tag_q  <= '0;
      line_q <= '0;
    end else if (flush || abort) begin
      busy_q <= 1'b0;
    end else if (!busy_q && start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      tag_q  <= start_tag;
      line_q <= start_line;
    end else if (busy_q && mem_gnt) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = {tag_q, {OFS_W{1'b0}}};
  assign fill_tag  = tag_q;
  assign fill_line = line_q;
  assign wr_en     = busy_q && mem_gnt && !flush && !abort;
  assign wr_ofs    = cnt_q;
  assign done      = wr_en && (cnt_q == LAST);

  // R3: the line address does not move while the request is up
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> $stable(mem_addr));

  // R4: the request drops right after the last word is taken
  assert_req_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_req);

  // R10: a flush ends any refill at the next edge
  assert_flush_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !mem_req);
endmodule

// File: rtl/icache_lru4.sv
module icache_lru4
  import icache_pkg::*;
#(
  parameter bit DIRECT_MAP  = 1'b0,
  parameter bit PREFETCH_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_req,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              stall,
  output logic [WORD_W-1:0] fetch_word,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_data
);
  logic [LINES-1:0] valid_q;
  tag_t [LINES-1:0] tags_q;
  word_t            data_q [LINES][WORDS];

  tag_t pc_tag;
  tag_t next_tag;
  ofs_t pc_ofs;
  logic hit_d;
  idx_t idx_d;
  logic hit_n;
  idx_t idx_n;

  assign pc_tag   = fetch_pc[PC_W-1:OFS_W];
  assign pc_ofs   = fetch_pc[OFS_W-1:0];
  assign next_tag = tag_t'(pc_tag + 1'b1);

  icache_lookup #(.DIRECT(DIRECT_MAP)) u_look_cur (
    .valid(valid_q), .tags(tags_q), .probe(pc_tag), .hit(hit_d), .idx(idx_d));

  icache_lookup #(.DIRECT(DIRECT_MAP)) u_look_next (
    .valid(valid_q), .tags(tags_q), .probe(next_tag), .hit(hit_n), .idx(idx_n));

  logic     busy;
  tag_t     fill_tag;
  idx_t     fill_line;
  logic     wr_en;
  ofs_t     wr_ofs;
  logic     done;
  logic     miss;
  logic     abort;
  logic     dem_start;
  logic     pf_start;
  logic     start;
  tag_t     start_tag;
  idx_t     victim;
  age_vec_t ages;

  always_comb begin
    miss      = fetch_req && !hit_d;
    abort     = busy && miss && (fill_tag != pc_tag);
    dem_start = !flush && !busy && miss;
    pf_start  = PREFETCH_EN && !flush && !busy && fetch_req && hit_d && !hit_n;
    start     = dem_start || pf_start;
    start_tag = dem_start ? pc_tag : next_tag;
    if (DIRECT_MAP) victim = start_tag[IDX_W-1:0];
    else            victim = pick_victim(valid_q, ages, pf_start, idx_d);
  end

  icache_fill u_fill (
    .clk(clk), .rst_n(rst_n), .flush(flush), .abort(abort),
    .start(start), .start_tag(start_tag), .start_line(victim),
    .mem_gnt(mem_gnt), .mem_req(mem_req), .mem_addr(mem_addr),
    .busy(busy), .fill_tag(fill_tag), .fill_line(fill_line),
    .wr_en(wr_en), .wr_ofs(wr_ofs), .done(done));

  icache_lru u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_a(done), .line_a(fill_line),
    .touch_b(fetch_req && hit_d), .line_b(idx_d),
    .ages(ages));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tags_q  <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      if (start) valid_q[victim] <= 1'b0;
      if (done) begin
        valid_q[fill_line] <= 1'b1;
        tags_q[fill_line]  <= fill_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[fill_line][wr_ofs] <= mem_data;
  end

  assign stall      = miss;
  assign fetch_word = data_q[idx_d][pc_ofs];

  // R10: flush leaves no valid line behind
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);

  // R8: a prefetch never targets the line being executed
  assert_pf_keeps_current_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_start |-> victim != idx_d);

  // R6: current and next line, both resident, sit in different lines
  assert_next_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && hit_d && hit_n |-> idx_n != idx_d);

  // R4: a line is never valid while it is being refilled
  assert_fill_line_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !valid_q[fill_line]);

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_uniq
      for (genvar j = i + 1; j < LINES; j++) begin : g_pair
        // R6: no tag is resident twice
        assert_unique_tags_R6: assert property (@(posedge clk) disable iff (!rst_n)
          valid_q[i] && valid_q[j] |-> tags_q[i] != tags_q[j]);
      end
    end
  endgenerate
endmodule

// File: tb/icache_lru4_tb_top.sv
`timescale 1ns/1ps

module icache_mem_model #(
  parameter int GAP = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_req,
  input  logic [15:0] mem_addr,
  output logic        mem_gnt,
  output logic [31:0] mem_data
);
  logic [2:0] cnt;
  int         ph;
  logic [15:0] wa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 0;
    end else if (!mem_req) begin
      cnt <= '0;
      ph  <= 0;
    end else begin
      ph <= (ph >= GAP) ? 0 : ph + 1;
      if (mem_gnt) cnt <= cnt + 1'b1;
    end
  end

  assign mem_gnt  = mem_req && (ph == 0);
  assign wa       = {mem_addr[15:3], cnt};
  assign mem_data = {wa ^ 16'hA5C3, ~wa};
endmodule

module icache_lru4_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_a [3];
  logic [15:0] pc_a  [3];
  logic        fl_a  [3];
  logic        st_a  [3];
  logic [31:0] wd_a  [3];
  logic        mr_a  [3];
  logic [15:0] ma_a  [3];
  logic        mg_a  [3];
  logic [31:0] md_a  [3];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  icache_lru4 #(.DIRECT_MAP(1'b0), .PREFETCH_EN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(fl_a[0]), .fetch_req(req_a[0]),
    .fetch_pc(pc_a[0]), .stall(st_a[0]), .fetch_word(wd_a[0]),
    .mem_req(mr_a[0]), .mem_addr(ma_a[0]), .mem_gnt(mg_a[0]), .mem_data(md_a[0]));
  icache_mem_model #(.GAP(0)) mem0_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mr_a[0]), .mem_addr(ma_a[0]),
    .mem_gnt(mg_a[0]), .mem_data(md_a[0]));

  icache_lru4 #(.DIRECT_MAP(1'b1), .PREFETCH_EN(1'b0)) dut_dm_i (
    .clk(clk), .rst_n(rst_n), .flush(fl_a[1]), .fetch_req(req_a[1]),
    .fetch_pc(pc_a[1]), .stall(st_a[1]), .fetch_word(wd_a[1]),
    .mem_req(mr_a[1]), .mem_addr(ma_a[1]), .mem_gnt(mg_a[1]), .mem_data(md_a[1]));
  icache_mem_model #(.GAP(2)) mem1_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mr_a[1]), .mem_addr(ma_a[1]),
    .mem_gnt(mg_a[1]), .mem_data(md_a[1]));

  icache_lru4 #(.DIRECT_MAP(1'b0), .PREFETCH_EN(1'b1)) dut_pf_i (
    .clk(clk), .rst_n(rst_n), .flush(fl_a[2]), .fetch_req(req_a[2]),
    .fetch_pc(pc_a[2]), .stall(st_a[2]), .fetch_word(wd_a[2]),
    .mem_req(mr_a[2]), .mem_addr(ma_a[2]), .mem_gnt(mg_a[2]), .mem_data(md_a[2]));
  icache_mem_model #(.GAP(0)) mem2_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mr_a[2]), .mem_addr(ma_a[2]),
    .mem_gnt(mg_a[2]), .mem_data(md_a[2]));

  function automatic logic [31:0] exp_word(logic [15:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic fetch(input int k, input logic [15:0] pc, input bit chk_req,
                       output bit missed, output int ncyc, output logic [31:0] w);
    @(negedge clk);
    req_a[k] = 1'b1;
    pc_a[k]  = pc;
    #2;
    missed = st_a[k];
    ncyc   = 0;
    while (st_a[k] && ncyc < 400) begin
      @(negedge clk);
      #2;
      ncyc++;
      if (ncyc == 1 && chk_req)
        check(mr_a[k] && ma_a[k] == (pc & 16'hFFF8), "R3", "refill request",
              {15'd0, mr_a[k], ma_a[k]}, {16'd1, pc & 16'hFFF8});
    end
    w = wd_a[k];
  endtask

  typedef struct packed {
    logic [15:0] pc;
    logic        miss;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{16'h0010, 1'b1}, '{16'h0013, 1'b0}, '{16'h0100, 1'b1}, '{16'h0200, 1'b1},
    '{16'h0300, 1'b1}, '{16'h0011, 1'b0}, '{16'h0105, 1'b0}, '{16'h0400, 1'b1},
    '{16'h0201, 1'b1}, '{16'h0107, 1'b0}, '{16'h0017, 1'b0}, '{16'h0302, 1'b1},
    '{16'h0404, 1'b1}
  };

  localparam vec_t VEC_DM [7] = '{
    '{16'h0000, 1'b1}, '{16'h0008, 1'b1}, '{16'h0003, 1'b0}, '{16'h0020, 1'b1},
    '{16'h0001, 1'b1}, '{16'h000F, 1'b0}, '{16'h0025, 1'b1}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit          m;
    int          n;
    logic [31:0] w;
    string       rq;
    for (int k = 0; k < 3; k++) begin
      req_a[k] = 1'b0;
      pc_a[k]  = '0;
      fl_a[k]  = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1: idle after reset
    check(!st_a[0] && !mr_a[0], "R1", "idle stall/req", {st_a[0], mr_a[0]}, 0);

    // Associative, no prefetch: table walk
    for (int i = 0; i < 13; i++) begin
      rq = (i == 0) ? "R1" : (i <= 6) ? "R6" : "R5";
      fetch(0, VEC[i].pc, VEC[i].miss, m, n, w);
      check(m == VEC[i].miss, rq, $sformatf("miss flag pc %h", VEC[i].pc), m, VEC[i].miss);
      check(w == exp_word(VEC[i].pc), "R2", "fetched word", w, exp_word(VEC[i].pc));
      if (VEC[i].miss) check(n == 9, "R4", "stall cycles", n, 9);
    end

    // R10: flush while idle
    @(negedge clk);
    req_a[0] = 1'b0;
    fl_a[0]  = 1'b1;
    @(negedge clk);
    fl_a[0] = 1'b0;
    fetch(0, 16'h0107, 1'b1, m, n, w);
    check(m == 1'b1, "R10", "miss after flush", m, 1);
    check(w == exp_word(16'h0107), "R10", "word after flush", w, exp_word(16'h0107));

    // R10: flush during refill
    @(negedge clk);
    req_a[0] = 1'b1;
    pc_a[0]  = 16'h0600;
    repeat (3) @(negedge clk);
    fl_a[0]  = 1'b1;
    req_a[0] = 1'b0;
    @(negedge clk);
    fl_a[0] = 1'b0;
    #2;
    check(!mr_a[0], "R10", "request after flush", mr_a[0], 0);
    fetch(0, 16'h0600, 1'b1, m, n, w);
    check(m == 1'b1 && n == 9, "R10", "abandoned line refetched", {m, n[30:0]}, {1'b1, 31'd9});
    @(negedge clk);
    req_a[0] = 1'b0;

    // R7: direct mapped, slow memory
    for (int i = 0; i < 7; i++) begin
      fetch(1, VEC_DM[i].pc, VEC_DM[i].miss, m, n, w);
      check(m == VEC_DM[i].miss, "R7", $sformatf("miss flag pc %h", VEC_DM[i].pc), m, VEC_DM[i].miss);
      check(w == exp_word(VEC_DM[i].pc), "R7", "fetched word", w, exp_word(VEC_DM[i].pc));
      if (i == 0) check(n == 23, "R4", "stall with grant gaps", n, 23);
    end
    @(negedge clk);
    req_a[1] = 1'b0;

    // R8: prefetch of next line
    fetch(2, 16'h1000, 1'b1, m, n, w);
    check(m == 1'b1 && n == 9, "R8", "first line miss", {m, n[30:0]}, {1'b1, 31'd9});
    @(negedge clk);
    #2;
    check(mr_a[2] && ma_a[2] == 16'h1008, "R8", "prefetch request",
          {15'd0, mr_a[2], ma_a[2]}, {16'd1, 16'h1008});
    repeat (10) @(negedge clk);
    fetch(2, 16'h100B, 1'b0, m, n, w);
    check(m == 1'b0, "R8", "prefetched line hits", m, 0);
    check(w == exp_word(16'h100B), "R8", "prefetched word", w, exp_word(16'h100B));
    fetch(2, 16'h1001, 1'b0, m, n, w);
    check(m == 1'b0, "R8", "current line kept", m, 0);
    @(negedge clk);
    req_a[2] = 1'b0;
    repeat (12) @(negedge clk);

    // R9: demand miss drops prefetch
    fetch(2, 16'h2000, 1'b1, m, n, w);
    fetch(2, 16'h3000, 1'b0, m, n, w);
    check(m == 1'b1 && n == 10, "R9", "demand after drop", {m, n[30:0]}, {1'b1, 31'd10});
    fetch(2, 16'h2008, 1'b0, m, n, w);
    check(m == 1'b1, "R9", "dropped line invalid", m, 1);
    check(w == exp_word(16'h2008), "R9", "word of refetched line", w, exp_word(16'h2008));
    fetch(2, 16'h4000, 1'b0, m, n, w);
    fetch(2, 16'h4008, 1'b0, m, n, w);
    check(m == 1'b1 && n == 8, "R9", "wait on prefetched line", {m, n[30:0]}, {1'b1, 31'd8});
    check(w == exp_word(16'h4008), "R9", "word of prefetched line", w, exp_word(16'h4008));
    @(negedge clk);
    req_a[2] = 1'b0;

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule